// File: doc/BRIEF.md
# Peak-Hold Power Meter PWM Driver

This block turns a stream of scaled forward-power readings into a pulse-width signal for a moving-coil panel meter. The needle jumps at once to any reading above the one it shows. It keeps that peak for a fixed hold interval, 2 s by default. It then falls back exponentially toward the most recent reading, with a time constant of about 300 ms. The decay uses a fixed-point shift-and-subtract step applied at a fixed tick rate.

A test input lets a host bypass the peak logic and set the duty directly. This is used to walk the needle through calibration marks. Full scale, duty 255, stands for 600 W. Duties 0, 43, 85, 128, 170, 213 and 255 are the 100 W marks, each being 42.5 counts per step rounded half up. The peak logic keeps running while the host is in control, so leaving test mode shows the current peak state.

Top module: `peak_meter_pwm`

## Requirements
- R1: A valid reading (`level_vld_i` high) that is strictly greater than the indicated value replaces it on that clock edge and restarts the full hold interval, whatever the current phase.
- R2: After a peak is captured, the indicated value stays unchanged for HOLD_MS milliseconds (CLK_HZ/1000*HOLD_MS clocks). Lower readings during that interval do not move it.
- R3: After the hold, the indicated value v decreases once every (CLK_HZ/1000*TAU_MS) >> DECAY_SHIFT clocks by max(v >> DECAY_SHIFT, 1). This gives a time constant of about TAU_MS. With TAU_MS=300 and DECAY_SHIFT=4, a peak of 200 reads about 75 after 16 steps.
- R4: The decay stops when the next step would reach or pass the latest valid reading. The indicated value then equals that reading and follows it.
- R5: While the indicated value is following the readings, a lower reading does not pull it down at once. It starts a new hold of the current value, followed by a decay toward the lower reading.
- R6: A reading above the indicated value that arrives during the decay ends the decay and starts a new full hold at the new value.
- R7: The PWM period is 256 prescaled steps of PWM_DIV clocks each. The output is high in the steps whose count is below the duty. Duty 0 never drives it high, and duty 255 drives it high in 255 of 256 steps.
- R8: While `test_en_i` is high, the duty is `test_duty_i` and readings have no effect on the output. The peak logic keeps running, so after `test_en_i` falls the output shows the peak captured during test mode.
- R9: Calibration duties 0, 43, 85, 128, 170, 213, 255 (round(42.5*k), k = 0..6) each produce exactly that many high clocks per 256-clock period. They mark 0 W to 600 W in 100 W steps.
- R10: After reset the indicated value is 0, the block follows the readings, and the output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 8 | Scaled forward-power reading, 255 = 600 W |
| level_vld_i | input | 1 | Reading strobe, one clock per reading |
| test_en_i | input | 1 | Direct duty mode enable |
| test_duty_i | input | 8 | Duty used in direct duty mode |
| pwm_o | output | 1 | Meter drive output |

## Verification
The bench builds the block with CLK_HZ=5000, HOLD_MS=2000, TAU_MS=300, DECAY_SHIFT=4 and PWM_DIV=1. This gives a 10,000-clock hold, a 93-clock decay step and a 256-clock PWM period. At these sizes a whole hold, a full exponential decay down to a lower reading, a peak that interrupts a decay, and a hold restarted before it expires all fit in a short run. With PWM_DIV=1, counting high clocks over any 256 consecutive clocks gives the duty exactly, so the indicated value can be read at the output pin alone.

// File: rtl/meter_pkg.sv
package meter_pkg;
  typedef enum logic [1:0] {
    MS_TRACK = 2'd0,
    MS_HOLD  = 2'd1,
    MS_DECAY = 2'd2
  } meter_st_e;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/peak_hold_fsm.sv
module peak_hold_fsm
  import meter_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned HOLD_CYC    = 100,
  parameter int unsigned DECAY_SHIFT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] level_i,
  input  logic          vld_i,
  input  logic          tick_i,
  output meter_st_e     state_o,
  output logic [DW-1:0] disp_o
);
  localparam int unsigned HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  meter_st_e     state_q;
  logic [DW-1:0] disp_q, live_q, live_nxt, step, dec_val;
  logic [HW-1:0] hold_q;
  logic          higher;

  assign higher   = vld_i && (level_i > disp_q);
  assign live_nxt = vld_i ? level_i : live_q;

  always_comb begin
    step = disp_q >> DECAY_SHIFT;
    if (step == '0) step = DW'(1);
    dec_val = disp_q - step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MS_TRACK;
      disp_q  <= '0;
      live_q  <= '0;
      hold_q  <= '0;
    end else begin
      if (vld_i) live_q <= level_i;
      if (higher) begin
        disp_q  <= level_i;
        state_q <= MS_HOLD;
        hold_q  <= '0;
      end else begin
        unique case (state_q)
          MS_TRACK: begin
            if (vld_i && (level_i < disp_q)) begin
              state_q <= MS_HOLD;
              hold_q  <= '0;
            end
          end
          MS_HOLD: begin
            if (hold_q == HOLD_LAST) begin
              if (disp_q > live_nxt) state_q <= MS_DECAY;
              else begin
                state_q <= MS_TRACK;
                disp_q  <= live_nxt;
              end
            end else begin
              hold_q <= hold_q + HW'(1);
            end
          end
          MS_DECAY: begin
            if (tick_i) begin
              if (dec_val <= live_nxt) begin
                disp_q  <= live_nxt;
                state_q <= MS_TRACK;
              end else begin
                disp_q <= dec_val;
              end
            end
          end
          default: state_q <= MS_TRACK;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign disp_o  = disp_q;

  assert_jump_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    higher |=> (disp_q == $past(level_i)) && (state_q == MS_HOLD));
  assert_hold_still_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_HOLD && !higher) |=> $stable(disp_q));
  assert_decay_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_DECAY && !higher) |=> disp_q <= $past(disp_q));
  assert_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_DECAY) |-> disp_q > live_q);
  assert_track_eq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_TRACK) |-> disp_q == live_q);
  assert_lower_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_TRACK && vld_i && level_i < disp_q) |=> (state_q == MS_HOLD) && $stable(disp_q));
  assert_repeak_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_DECAY && higher) |=> state_q == MS_HOLD);
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [DW-1:0] duty_i,
  output logic          pwm_o
);
  logic [DW-1:0] cnt_q;
  logic          pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (step_i) cnt_q <= cnt_q + DW'(1);
      pwm_q <= (cnt_q < duty_i);
    end
  end

  assign pwm_o = pwm_q;

  assert_zero_duty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == '0) |=> !pwm_o);
  assert_full_duty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == '1 && cnt_q != '1) |=> pwm_o);
endmodule

// File: rtl/peak_meter_pwm.sv
module peak_meter_pwm
  import meter_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned HOLD_MS     = 2000,
  parameter int unsigned TAU_MS      = 300,
  parameter int unsigned DECAY_SHIFT = 4,
  parameter int unsigned PWM_DIV     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] level_i,
  input  logic       level_vld_i,
  input  logic       test_en_i,
  input  logic [7:0] test_duty_i,
  output logic       pwm_o
);
  localparam int unsigned DW        = 8;
  localparam int unsigned CYC_MS    = CLK_HZ / 1000;
  localparam int unsigned HOLD_CYC  = CYC_MS * HOLD_MS;
  localparam int unsigned DEC_RAW   = (CYC_MS * TAU_MS) >> DECAY_SHIFT;
  localparam int unsigned DECAY_CYC = (DEC_RAW > 0) ? DEC_RAW : 1;

  meter_st_e     state;
  logic [DW-1:0] disp, duty;
  logic          dec_tick, pwm_step;

  tick_div #(.DIV(DECAY_CYC)) u_decay_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state != MS_DECAY),
    .tick_o (dec_tick)
  );

  peak_hold_fsm #(
    .DW          (DW),
    .HOLD_CYC    (HOLD_CYC),
    .DECAY_SHIFT (DECAY_SHIFT)
  ) u_peak (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level_i),
    .vld_i   (level_vld_i),
    .tick_i  (dec_tick),
    .state_o (state),
    .disp_o  (disp)
  );

  tick_div #(.DIV(PWM_DIV)) u_pwm_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .tick_o (pwm_step)
  );

  assign duty = test_en_i ? test_duty_i : disp;

  pwm_core #(.DW(DW)) u_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (pwm_step),
    .duty_i (duty),
    .pwm_o  (pwm_o)
  );

  assert_decay_paced_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == MS_DECAY && !dec_tick && !(level_vld_i && level_i > disp)) |=> $stable(disp));
  assert_test_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && test_duty_i == '0) |=> !pwm_o);
endmodule

// File: tb/sim_peak_meter_pwm.sv
module sim_peak_meter_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] level = '0;
  logic       vld = 1'b0;
  logic       test_en = 1'b0;
  logic [7:0] test_duty = '0;
  logic       pwm;

  int total = 0;
  int bad = 0;
  int t = 0;

  always #10 clk = ~clk;

  peak_meter_pwm #(
    .CLK_HZ(5000), .HOLD_MS(2000), .TAU_MS(300), .DECAY_SHIFT(4), .PWM_DIV(1)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .level_i(level), .level_vld_i(vld),
    .test_en_i(test_en), .test_duty_i(test_duty), .pwm_o(pwm)
  );

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    t += n;
  endtask

  task automatic adv_to(int target);
    while (t < target) idle(1);
  endtask

  task automatic send(logic [7:0] v);
    @(negedge clk); level = v; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    t += 2;
  endtask

  task automatic measure(output int cnt);
    cnt = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm) cnt++;
    end
    t += 256;
  endtask

  task automatic chk(string req, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vld = 1'b0; test_en = 1'b0; level = '0; test_duty = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic t_reset();
    int c;
    do_reset();
    measure(c);
    chk("R10 reset output low", c, 0, 0);
  endtask

  task automatic t_hold_decay();
    int c;
    do_reset();
    send(8'd200);
    t = 0;
    send(8'd20);
    measure(c);
    chk("R1 immediate jump", c, 200, 200);
    adv_to(9700);
    measure(c);
    chk("R2 held through hold", c, 200, 200);
    adv_to(10100);
    measure(c);
    chk("R3 decay begun", c, 150, 199);
    adv_to(11400);
    measure(c);
    chk("R3 about 1/e after tau", c, 65, 90);
    adv_to(20000);
    measure(c);
    chk("R4 settled at live", c, 20, 20);
    send(8'd10);
    t = 0;
    measure(c);
    chk("R5 lower holds current", c, 20, 20);
    adv_to(9500);
    measure(c);
    chk("R5 still held", c, 20, 20);
    adv_to(12500);
    measure(c);
    chk("R5 decayed to lower", c, 10, 10);
  endtask

  task automatic t_repeak();
    int c;
    do_reset();
    send(8'd240);
    t = 0;
    send(8'd5);
    adv_to(10200);
    send(8'd230);
    t = 0;
    measure(c);
    chk("R6 new peak in decay", c, 230, 230);
    adv_to(9400);
    measure(c);
    chk("R6 new hold after decay", c, 230, 230);
  endtask

  task automatic t_restart();
    int c;
    do_reset();
    send(8'd100);
    t = 0;
    send(8'd30);
    adv_to(5000);
    send(8'd150);
    measure(c);
    chk("R1 jump during hold", c, 150, 150);
    adv_to(11000);
    measure(c);
    chk("R1 hold restarted", c, 150, 150);
  endtask

  task automatic t_test_mode();
    int c;
    do_reset();
    test_en = 1'b1;
    for (int k = 0; k <= 6; k++) begin
      test_duty = 8'((k * 85 + 1) / 2);
      idle(3);
      measure(c);
      chk("R9 calibration step", c, (k * 85 + 1) / 2, (k * 85 + 1) / 2);
      if (k == 0) chk("R7 zero duty", c, 0, 0);
      if (k == 6) chk("R7 full duty", c, 255, 255);
    end
    test_duty = 8'd85;
    send(8'd250);
    idle(2);
    measure(c);
    chk("R8 readings ignored in test", c, 85, 85);
    test_en = 1'b0;
    idle(2);
    measure(c);
    chk("R8 peak kept after test", c, 250, 250);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_hold_decay();
    t_repeak();
    t_restart();
    t_test_mode();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule